// File: doc/BRIEF.md
# Command Queue Consumer Engine

This block drains a small circular command buffer that a host fills over a direct write port. Each buffer slot holds one 128-bit command, given as two 64-bit words. The host writes one or more commands at the slots after the last published position. It then publishes them by writing a new producer pointer. While the engine is enabled, it takes the slot at its consumer pointer on every clock until the two pointers match. For each command it decodes the opcode, raises the matching one-cycle action pulse, and advances the consumer pointer. The host learns that its batch is complete by polling the consumer pointer until it equals the value it published. A trailing synchronisation command gives a pulse that marks the end of a batch.

Both pointers are one bit wider than the slot index. The top bit is a wrap flag, so the engine can tell a completely full buffer from an empty one. An opcode the engine does not recognise stops consumption at that slot and raises a sticky error request toward the global error logic. The engine resumes from the same slot after that request is acknowledged, which gives the host a chance to repair the slot first. All ports are plain control and status pins. There is no back-pressure, because the engine must react to every pulse it emits in the cycle it emits it, and the host paces itself by polling the pointer.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset, both pointers read 0, the error flag is 0 and no action pulse is high.
- R2: A producer-register write keeps only the low 5 bits of `prod_wr_data` and shows them on `prod_ptr_o` in the next cycle. Bits 3:0 are the slot index and bit 4 is the wrap flag.
- R3: The engine consumes at most one slot per clock. Each step adds 1 to the consumer pointer modulo 32, so the wrap flag toggles after slot 15. A batch of N slots published at one edge completes N+1 cycles after the write is presented.
- R4: Commands are consumed only while bit 3 of the control register is 1. While it is 0, the consumer pointer holds its value, and the other control bits have no effect.
- R5: The buffer is empty when the two pointers are equal in all 5 bits, and nothing is consumed then. It is full when the indices match but the wrap flags differ, and then all 16 slots are consumed.
- R6: The opcode is bits 7:0 of the low word. The opcodes 0x03, 0x04, 0x05, 0x06, 0x11, 0x20 and 0x30 each raise exactly one one-cycle pulse: `cfg_ste_o`, `cfg_all_o`, `cfg_cd_o`, `cfg_cd_all_o`, `inv_asid_o`, `inv_el2_o` and `inv_nsnh_o`, in that order. The pulse comes in the same cycle that the consumer pointer moves past the slot, and at most one pulse is high in any cycle.
- R7: During an `inv_asid_o` pulse, `inv_asid_val_o` carries bits 63:48 of the low word of that command.
- R8: During a `cfg_all_o` pulse, `cfg_range_o` carries bits 4:0 of the high word of that command, where 0x1F means the whole range.
- R9: Opcode 0x46 (sync) raises `sync_done_o` for one cycle. When sync is the last command of a batch, the consumer pointer equals the producer pointer in that same cycle.
- R10: Opcode 0x01 (prefetch) advances the consumer pointer and raises no pulse.
- R11: Any other opcode sets `cmd_err_o`. The consumer pointer stays at that slot, no pulse is raised, and the flag stays set until it is acknowledged.
- R12: A one-cycle `err_ack` clears `cmd_err_o`. The engine then reads the same slot again, as it stands after any rewrite by the host, and continues from there.
- R13: A producer write that lands in the same cycle the engine consumes the last published slot takes effect without a gap. Consumption continues on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_wr_en | input | 1 | Write one buffer slot |
| buf_wr_idx | input | 4 | Slot index for the write |
| buf_wr_lo | input | 64 | Low command word (opcode, ASID) |
| buf_wr_hi | input | 64 | High command word (range) |
| prod_wr_en | input | 1 | Producer register write strobe |
| prod_wr_data | input | 32 | Producer register write data |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 32 | Control register write data, bit 3 enables consumption |
| err_ack | input | 1 | Acknowledge and clear the command error |
| prod_ptr_o | output | 5 | Producer pointer (wrap flag plus index) |
| cons_ptr_o | output | 5 | Consumer pointer (wrap flag plus index) |
| cfg_ste_o | output | 1 | Stream-entry configuration invalidation pulse |
| cfg_all_o | output | 1 | Configuration invalidate-all pulse |
| cfg_cd_o | output | 1 | Context-descriptor invalidation pulse |
| cfg_cd_all_o | output | 1 | All-context-descriptor invalidation pulse |
| inv_asid_o | output | 1 | TLB invalidation by ASID pulse |
| inv_el2_o | output | 1 | Hypervisor-level TLB invalidate-all pulse |
| inv_nsnh_o | output | 1 | Non-hypervisor TLB invalidate-all pulse |
| sync_done_o | output | 1 | Sync command completion pulse |
| inv_asid_val_o | output | 16 | ASID that goes with `inv_asid_o` |
| cfg_range_o | output | 5 | Range that goes with `cfg_all_o` |
| cmd_err_o | output | 1 | Sticky unknown-opcode error request |

## Verification
Two functions can fall in the same clock: the host's producer-register write and the engine's consumption of the slot that was last published. The bench provokes this by publishing two slots, then timing a second write that extends the batch so that it lands on the edge where the second slot is consumed. It judges the result by sampling the consumer pointer on the following cycles and expecting it to rise by exactly one on each of them, with no idle cycle between the two batches. A second pair, an error acknowledgement arriving while the engine sits halted, is checked by expecting the repaired slot to be consumed and its pulse to appear.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int unsigned OP_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_PREFETCH   = 8'h01,
    OP_CFG_STE    = 8'h03,
    OP_CFG_ALL    = 8'h04,
    OP_CFG_CD     = 8'h05,
    OP_CFG_CD_ALL = 8'h06,
    OP_INV_ASID   = 8'h11,
    OP_INV_EL2    = 8'h20,
    OP_INV_NSNH   = 8'h30,
    OP_SYNC       = 8'h46
  } cmd_op_e;

  // Positions in the action pulse vector
  localparam int unsigned ACT_CFG_STE    = 0;
  localparam int unsigned ACT_CFG_ALL    = 1;
  localparam int unsigned ACT_CFG_CD     = 2;
  localparam int unsigned ACT_CFG_CD_ALL = 3;
  localparam int unsigned ACT_INV_ASID   = 4;
  localparam int unsigned ACT_INV_EL2    = 5;
  localparam int unsigned ACT_INV_NSNH   = 6;
  localparam int unsigned ACT_SYNC       = 7;
  localparam int unsigned NUM_ACT        = 8;

endpackage

// File: rtl/cmdq_store.sv
// Slot storage: keeps only the command fields the engine decodes.
module cmdq_store #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned ENT_W = 29
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q[g] <= wr_ent;
      end
    end
  end

  assign rd_ent = slot_q[rd_idx];
endmodule

// File: rtl/cmdq_ptrs.sv
// Producer/consumer pointers with a wrap flag above the index.
module cmdq_ptrs #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_wr_en,
  input  logic [REG_W-1:0] prod_wr_data,
  input  logic             adv_i,
  output logic [IDX_W:0]   prod_o,
  output logic [IDX_W:0]   cons_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] prod_q, cons_q;
  logic             unused_prod_hi;

  assign unused_prod_hi = ^prod_wr_data[REG_W-1:PTR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (prod_wr_en) begin
      prod_q <= prod_wr_data[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_q <= '0;
    end else if (adv_i) begin
      cons_q <= cons_q + PTR_W'(1);
    end
  end

  assign empty_o = (prod_q == cons_q);
  assign full_o  = (prod_q[IDX_W-1:0] == cons_q[IDX_W-1:0]) &&
                   (prod_q[IDX_W] != cons_q[IDX_W]);
  assign prod_o  = prod_q;
  assign cons_o  = cons_q;
endmodule

// File: rtl/cmdq_decode.sv
// Opcode decode into a one-hot action vector.
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  output logic               known_o,
  output logic [NUM_ACT-1:0] act_o
);
  always_comb begin
    known_o = 1'b1;
    act_o   = '0;
    case (op_i)
      OP_PREFETCH:   act_o = '0;
      OP_CFG_STE:    act_o[ACT_CFG_STE]    = 1'b1;
      OP_CFG_ALL:    act_o[ACT_CFG_ALL]    = 1'b1;
      OP_CFG_CD:     act_o[ACT_CFG_CD]     = 1'b1;
      OP_CFG_CD_ALL: act_o[ACT_CFG_CD_ALL] = 1'b1;
      OP_INV_ASID:   act_o[ACT_INV_ASID]   = 1'b1;
      OP_INV_EL2:    act_o[ACT_INV_EL2]    = 1'b1;
      OP_INV_NSNH:   act_o[ACT_INV_NSNH]   = 1'b1;
      OP_SYNC:       act_o[ACT_SYNC]       = 1'b1;
      default:       known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned ASID_W   = 16,
  parameter int unsigned ASID_LSB = 48,
  parameter int unsigned RANGE_W  = 5,
  parameter int unsigned EN_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr_en,
  input  logic [IDX_W-1:0]  buf_wr_idx,
  input  logic [WORD_W-1:0] buf_wr_lo,
  input  logic [WORD_W-1:0] buf_wr_hi,
  input  logic              prod_wr_en,
  input  logic [REG_W-1:0]  prod_wr_data,
  input  logic              ctrl_wr_en,
  input  logic [REG_W-1:0]  ctrl_wr_data,
  input  logic              err_ack,
  output logic [IDX_W:0]    prod_ptr_o,
  output logic [IDX_W:0]    cons_ptr_o,
  output logic              cfg_ste_o,
  output logic              cfg_all_o,
  output logic              cfg_cd_o,
  output logic              cfg_cd_all_o,
  output logic              inv_asid_o,
  output logic              inv_el2_o,
  output logic              inv_nsnh_o,
  output logic              sync_done_o,
  output logic [ASID_W-1:0] inv_asid_val_o,
  output logic [RANGE_W-1:0] cfg_range_o,
  output logic              cmd_err_o
);
  localparam int unsigned ENT_W = OP_W + ASID_W + RANGE_W;

  // Stored slot fields: {range, asid, opcode}
  logic [ENT_W-1:0]   wr_ent, rd_ent;
  logic [OP_W-1:0]    rd_op;
  logic [ASID_W-1:0]  rd_asid;
  logic [RANGE_W-1:0] rd_range;
  logic               unused_words;

  assign wr_ent = {buf_wr_hi[RANGE_W-1:0],
                   buf_wr_lo[ASID_LSB +: ASID_W],
                   buf_wr_lo[OP_W-1:0]};
  assign unused_words = ^{buf_wr_hi[WORD_W-1:RANGE_W],
                          buf_wr_lo[ASID_LSB-1:OP_W]};

  cmdq_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk    (clk),
    .wr_en  (buf_wr_en),
    .wr_idx (buf_wr_idx),
    .wr_ent (wr_ent),
    .rd_idx (cons_ptr_o[IDX_W-1:0]),
    .rd_ent (rd_ent)
  );

  assign rd_op    = rd_ent[OP_W-1:0];
  assign rd_asid  = rd_ent[OP_W +: ASID_W];
  assign rd_range = rd_ent[OP_W+ASID_W +: RANGE_W];

  // Control register: only the enable bit is kept
  logic ctrl_en_q;
  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_wr_data[REG_W-1:EN_BIT+1], ctrl_wr_data[EN_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
    end else if (ctrl_wr_en) begin
      ctrl_en_q <= ctrl_wr_data[EN_BIT];
    end
  end

  // Step control
  logic               q_empty, q_full, err_q, go, adv, err_set, dec_known;
  logic [NUM_ACT-1:0] dec_act, act_q;
  logic               unused_full;

  cmdq_decode u_dec (
    .op_i    (rd_op),
    .known_o (dec_known),
    .act_o   (dec_act)
  );

  assign go      = ctrl_en_q && !err_q && !q_empty;
  assign adv     = go && dec_known;
  assign err_set = go && !dec_known;
  assign unused_full = q_full;

  cmdq_ptrs #(.IDX_W(IDX_W), .REG_W(REG_W)) u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .prod_wr_en   (prod_wr_en),
    .prod_wr_data (prod_wr_data),
    .adv_i        (adv),
    .prod_o       (prod_ptr_o),
    .cons_o       (cons_ptr_o),
    .empty_o      (q_empty),
    .full_o       (q_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end else if (err_ack) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q          <= '0;
      inv_asid_val_o <= '0;
      cfg_range_o    <= '0;
    end else begin
      act_q <= adv ? dec_act : '0;
      if (adv && dec_act[ACT_INV_ASID]) inv_asid_val_o <= rd_asid;
      if (adv && dec_act[ACT_CFG_ALL])  cfg_range_o    <= rd_range;
    end
  end

  assign cfg_ste_o    = act_q[ACT_CFG_STE];
  assign cfg_all_o    = act_q[ACT_CFG_ALL];
  assign cfg_cd_o     = act_q[ACT_CFG_CD];
  assign cfg_cd_all_o = act_q[ACT_CFG_CD_ALL];
  assign inv_asid_o   = act_q[ACT_INV_ASID];
  assign inv_el2_o    = act_q[ACT_INV_EL2];
  assign inv_nsnh_o   = act_q[ACT_INV_NSNH];
  assign sync_done_o  = act_q[ACT_SYNC];
  assign cmd_err_o    = err_q;
endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int unsigned PTR_W   = 5,
  parameter int unsigned NUM_ACT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PTR_W-1:0]   cons_i,
  input logic [PTR_W-1:0]   prod_i,
  input logic [NUM_ACT-1:0] act_i,
  input logic               en_i,
  input logic               err_i,
  input logic               err_ack_i
);
  // R3: the consumer pointer only ever steps by one, modulo 2^PTR_W
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_i != $past(cons_i)) |-> (cons_i == PTR_W'($past(cons_i) + 1'b1)));

  // R4: with the enable bit clear the consumer pointer holds
  a_r4_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cons_i));

  // R5: an empty queue is never consumed
  a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_i == prod_i) |=> $stable(cons_i));

  // R6: pulses are mutually exclusive and coincide with a pointer step
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_i));
  a_r6_pulse_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_i) |-> (cons_i != $past(cons_i)));

  // R11: the error is sticky and freezes consumption
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !err_ack_i) |=> err_i);
  a_r11_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> $stable(cons_i));

  // R12: an acknowledge clears the error
  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && err_ack_i) |=> !err_i);
endmodule

bind cmdq_consumer cmdq_consumer_chk #(
  .PTR_W   (IDX_W + 1),
  .NUM_ACT (cmdq_pkg::NUM_ACT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cons_i    (cons_ptr_o),
  .prod_i    (prod_ptr_o),
  .act_i     (act_q),
  .en_i      (ctrl_en_q),
  .err_i     (cmd_err_o),
  .err_ack_i (err_ack)
);

// File: tb/cmdq_consumer_tb_top.sv
module cmdq_consumer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        buf_wr_en, prod_wr_en, ctrl_wr_en, err_ack;
  logic [3:0]  buf_wr_idx;
  logic [63:0] buf_wr_lo, buf_wr_hi;
  logic [31:0] prod_wr_data, ctrl_wr_data;
  logic [4:0]  prod_ptr_o, cons_ptr_o;
  logic        cfg_ste_o, cfg_all_o, cfg_cd_o, cfg_cd_all_o;
  logic        inv_asid_o, inv_el2_o, inv_nsnh_o, sync_done_o, cmd_err_o;
  logic [15:0] inv_asid_val_o;
  logic [4:0]  cfg_range_o;

  cmdq_consumer dut_i (
    .clk(clk), .rst_n(rst_n),
    .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx),
    .buf_wr_lo(buf_wr_lo), .buf_wr_hi(buf_wr_hi),
    .prod_wr_en(prod_wr_en), .prod_wr_data(prod_wr_data),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .err_ack(err_ack),
    .prod_ptr_o(prod_ptr_o), .cons_ptr_o(cons_ptr_o),
    .cfg_ste_o(cfg_ste_o), .cfg_all_o(cfg_all_o), .cfg_cd_o(cfg_cd_o),
    .cfg_cd_all_o(cfg_cd_all_o), .inv_asid_o(inv_asid_o),
    .inv_el2_o(inv_el2_o), .inv_nsnh_o(inv_nsnh_o),
    .sync_done_o(sync_done_o), .inv_asid_val_o(inv_asid_val_o),
    .cfg_range_o(cfg_range_o), .cmd_err_o(cmd_err_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] sw_prod = '0;

  // Pulse monitor, sampled on the falling edge
  logic [7:0] pulses;
  assign pulses = {sync_done_o, inv_nsnh_o, inv_el2_o, inv_asid_o,
                   cfg_cd_all_o, cfg_cd_o, cfg_all_o, cfg_ste_o};
  int cnt [8];
  int total = 0;
  int multi = 0;
  logic [15:0] seen_asid = '0;
  logic [4:0]  seen_range = '0;
  logic        sync_at_end = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 8; k++) if (pulses[k]) cnt[k]++;
      if ($countones(pulses) > 1) multi++;
      total += $countones(pulses);
      if (inv_asid_o) seen_asid = inv_asid_val_o;
      if (cfg_all_o) seen_range = cfg_range_o;
      if (sync_done_o) sync_at_end = (cons_ptr_o == prod_ptr_o);
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lo_word(input logic [7:0] op, input logic [15:0] asid);
    return {asid, 40'h12_3456_789A, op};
  endfunction

  task automatic write_at(input logic [3:0] idx, input logic [63:0] lo, input logic [63:0] hi);
    @(negedge clk);
    buf_wr_en = 1'b1; buf_wr_idx = idx; buf_wr_lo = lo; buf_wr_hi = hi;
    @(negedge clk);
    buf_wr_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] op, input logic [15:0] asid, input logic [63:0] hi);
    write_at(sw_prod[3:0], lo_word(op, asid), hi);
    sw_prod = sw_prod + 5'd1;
  endtask

  task automatic publish(input logic [4:0] val);
    @(negedge clk);
    prod_wr_en = 1'b1; prod_wr_data = {27'h5A5A5A5, val};
    @(negedge clk);
    prod_wr_en = 1'b0;
  endtask

  task automatic set_en(input bit on);
    @(negedge clk);
    ctrl_wr_en = 1'b1;
    ctrl_wr_data = on ? 32'hA5A5_A5AD : 32'hFFFF_FFF7;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100; i++) begin
      if (cons_ptr_o == sw_prod) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(prod_ptr_o == 5'd0, "R1 prod reset", prod_ptr_o, 0);
    check(cons_ptr_o == 5'd0, "R1 cons reset", cons_ptr_o, 0);
    check(cmd_err_o == 1'b0,  "R1 err reset", cmd_err_o, 0);
    check(pulses == 8'd0,     "R1 no pulse", pulses, 0);
  endtask

  task automatic t_decode();
    int base_total;
    base_total = total;
    set_en(1'b1);
    push(8'h03, 16'h0, 64'h0);
    push(8'h04, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF);  // range field 0x1F
    push(8'h05, 16'h0, 64'h0);
    push(8'h06, 16'h0, 64'h0);
    push(8'h11, 16'hBEEF, 64'h0);
    push(8'h20, 16'h0, 64'h0);
    push(8'h01, 16'h0, 64'h0);
    push(8'h30, 16'h0, 64'h0);
    push(8'h46, 16'h0, 64'h0);
    publish(sw_prod);
    drain();
    for (int k = 0; k < 8; k++) check(cnt[k] == 1, "R6 one pulse per opcode", cnt[k], 1);
    check(total - base_total == 8, "R10 prefetch gives no pulse", total - base_total, 8);
    check(multi == 0, "R6 pulses exclusive", multi, 0);
    check(seen_asid == 16'hBEEF, "R7 asid side bus", seen_asid, 16'hBEEF);
    check(seen_range == 5'h1F, "R8 range field", seen_range, 5'h1F);
    check(sync_at_end, "R9 sync with pointers equal", sync_at_end, 1);
    check(cons_ptr_o == 5'd9, "R10 pointer after batch", cons_ptr_o, 9);
  endtask

  task automatic t_rate();
    int first;
    first = -1;
    for (int i = 0; i < 4; i++) push(8'h01, 16'h0, 64'h0);
    @(negedge clk);
    prod_wr_en = 1'b1; prod_wr_data = {27'h0, sw_prod};
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      prod_wr_en = 1'b0;
      if (first < 0 && cons_ptr_o == sw_prod) first = k;
    end
    check(first == 5, "R3 one slot per clock", first, 5);
  endtask

  task automatic t_gate_and_wrap();
    logic [4:0] c0;
    set_en(1'b0);
    c0 = cons_ptr_o;
    for (int i = 0; i < 3; i++) push(8'h06, 16'h0, 64'h0);
    publish(sw_prod);
    repeat (10) @(negedge clk);
    check(cons_ptr_o == c0, "R4 disabled holds pointer", cons_ptr_o, c0);
    set_en(1'b1);
    drain();
    check(cons_ptr_o == 5'h10, "R3 wrap flag toggles", cons_ptr_o, 5'h10);
  endtask

  task automatic t_full_empty();
    logic [4:0] c0;
    int cd0;
    set_en(1'b0);
    c0 = cons_ptr_o;
    cd0 = cnt[2];
    for (int i = 0; i < 16; i++) push(8'h05, 16'h0, 64'h0);
    publish(sw_prod);
    check(prod_ptr_o == (c0 ^ 5'h10), "R2 prod low bits kept", prod_ptr_o, c0 ^ 5'h10);
    set_en(1'b1);
    drain();
    check(cnt[2] - cd0 == 16, "R5 full queue drained", cnt[2] - cd0, 16);
    check(cons_ptr_o == sw_prod, "R5 full queue pointer", cons_ptr_o, sw_prod);
    c0 = cons_ptr_o;
    cd0 = total;
    repeat (8) @(negedge clk);
    check(cons_ptr_o == c0 && total == cd0, "R5 empty idle", cons_ptr_o, c0);
  endtask

  task automatic t_error();
    logic [4:0] c0;
    int t0, a0;
    c0 = cons_ptr_o;
    t0 = total;
    a0 = cnt[1];
    push(8'h7F, 16'h0, 64'h0);
    push(8'h01, 16'h0, 64'h0);
    publish(sw_prod);
    repeat (8) @(negedge clk);
    check(cmd_err_o == 1'b1, "R11 error raised", cmd_err_o, 1);
    check(cons_ptr_o == c0, "R11 halts at bad slot", cons_ptr_o, c0);
    check(total == t0, "R11 no pulse on bad opcode", total - t0, 0);
    write_at(c0[3:0], lo_word(8'h04, 16'h0), 64'h3);
    repeat (3) @(negedge clk);
    check(cmd_err_o == 1'b1, "R11 error sticky", cmd_err_o, 1);
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
    drain();
    check(cmd_err_o == 1'b0, "R12 ack clears", cmd_err_o, 0);
    check(cnt[1] - a0 == 1, "R12 repaired slot consumed", cnt[1] - a0, 1);
    check(seen_range == 5'h03, "R8 partial range", seen_range, 5'h03);
    check(cons_ptr_o == sw_prod, "R12 resumes to end", cons_ptr_o, sw_prod);
  endtask

  task automatic t_collide();
    logic [4:0] b;
    b = sw_prod;
    for (int i = 0; i < 4; i++) push(8'h01, 16'h0, 64'h0);
    @(negedge clk);
    prod_wr_en = 1'b1; prod_wr_data = {27'h0, b + 5'd2};
    @(negedge clk); prod_wr_en = 1'b0;
    @(negedge clk);
    prod_wr_en = 1'b1; prod_wr_data = {27'h0, b + 5'd4};
    check(cons_ptr_o == b + 5'd1, "R13 first step", cons_ptr_o, b + 5'd1);
    @(negedge clk); prod_wr_en = 1'b0;
    check(cons_ptr_o == b + 5'd2, "R13 step at publish edge", cons_ptr_o, b + 5'd2);
    @(negedge clk);
    check(cons_ptr_o == b + 5'd3, "R13 no gap", cons_ptr_o, b + 5'd3);
    @(negedge clk);
    check(cons_ptr_o == b + 5'd4, "R13 batch end", cons_ptr_o, b + 5'd4);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    rst_n = 1'b0;
    buf_wr_en = 1'b0; buf_wr_idx = '0; buf_wr_lo = '0; buf_wr_hi = '0;
    prod_wr_en = 1'b0; prod_wr_data = '0;
    ctrl_wr_en = 1'b0; ctrl_wr_data = '0; err_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_rate();
    t_gate_and_wrap();
    t_full_empty();
    t_error();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule